// File: doc/BRIEF.md
# Speculative Cache Violation Tracker

This block is a small direct-mapped data cache that sits beside one core while the core runs transactions. While a transaction is open, every access is tracked. A load sets a per-line read mark. A store sets a per-line modified mark and a per-word renamed mark. The cache also watches a stream of line addresses that other cores have just committed. If a committed line is one this core has speculatively read, the block raises a violation flag, and the core must abort and retry.

The renamed marks keep a local write-after-read from counting as a conflict. Once the core has written a word itself, later loads of that word return its own value and do not set the read mark. A snoop of that line then leaves the transaction alone, unless some other word of the line was read from outside.

On abort, the block drops every line the transaction modified and clears all tracking marks. Lines that were only read stay in the cache.

On commit, the block streams out the address of each modified line, lowest index first, over a valid/ready channel so that a packet builder can gather them. It then clears all marks and keeps the written data.

There is no refill path. Data words become valid only when a store writes them. A load that misses allocates the line for tracking only.

The load response and the snoop input carry no back-pressure: the core must take every response, and the cache takes every snoop. The commit list is the only stream. It follows these rules:
- `cpkt_valid_o` and `cpkt_line_o` stay unchanged while `cpkt_ready_i` is low.
- A transfer happens on each clock edge where both valid and ready are high.
- A request is accepted on an edge where `req_valid_i` and `req_ready_o` are both high.

Top module: `spec_viol_cache`

Address layout: a word address is {tag, index, word}, with the word field in the low bits. The line address is the word address shifted right by log2(LINE_WORDS). Its low bits are the index.

## Requirements
- R1: After reset, `violation_o`, `txn_active_o`, `cpkt_valid_o` and `commit_done_o` are low, `req_ready_o` is high, and every load misses (`rsp_hit_o` low).
- R2: With no transaction open, a `txn_begin_i` pulse opens one, and `txn_active_o` is high from the next cycle. An abort closes it, and `txn_active_o` is low from the next cycle.
- R3: Inside a transaction, a load sets the read mark of its line. A later snoop of that line address sets `violation_o` in the cycle after the snoop.
- R4: A store inside a transaction sets the renamed mark of its word. A later load of that same word does not set the read mark, so a snoop of the line gives no violation. A load of an unwritten word of the same line does set the read mark.
- R5: A snoop of a line in the same cycle as an accepted transactional load of that line, to a word that is not renamed, raises a violation.
- R6: `violation_o` stays high until an abort. A commit strobe while it is high has no effect: no commit entry is emitted, `commit_done_o` stays low, and the transaction stays open.
- R7: An abort clears `violation_o` and all marks. It invalidates the lines that the transaction modified, so later loads to them miss, and keeps the lines that were only read, along with their data.
- R8: A commit with no violation emits, over the valid/ready channel, the full line address of every modified line in ascending index order. The channel holds steady under back-pressure and `req_ready_o` stays low throughout. `commit_done_o` pulses one cycle after the last transfer. Written data stays valid and all marks are cleared.
- R9: Inside a transaction, an access whose index holds a different line with a read or modified mark raises a violation. The access is not performed: a load reports a miss and a store writes nothing.
- R10: Outside a transaction, loads and stores set no marks and snoops never raise a violation.
- R11: Each accepted load gives `rsp_valid_o` for exactly one cycle, in the cycle after acceptance. `rsp_hit_o` is high only when the line is present and the word was written by a store, and `rsp_rdata_o` then carries that word.
- R12: `req_ready_o` is low in any cycle with a begin, commit or abort strobe, and throughout commit draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_begin_i | input | 1 | Open a transaction (one-cycle strobe) |
| txn_commit_i | input | 1 | Request commit of the open transaction |
| txn_abort_i | input | 1 | Abort the transaction and acknowledge a violation |
| req_valid_i | input | 1 | Core access request valid |
| req_ready_o | output | 1 | Cache accepts a request this cycle |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W (16) | Word address |
| req_wdata_i | input | DATA_W (32) | Store data |
| rsp_valid_o | output | 1 | Load response valid |
| rsp_hit_o | output | 1 | Loaded word was present |
| rsp_rdata_o | output | DATA_W (32) | Loaded word |
| snoop_valid_i | input | 1 | Committed line address from another core is valid |
| snoop_line_i | input | ADDR_W-log2(LINE_WORDS) (14) | Committed line address |
| violation_o | output | 1 | Sticky conflict flag |
| txn_active_o | output | 1 | A transaction is open (including while draining) |
| cpkt_valid_o | output | 1 | A modified line address is offered |
| cpkt_ready_i | input | 1 | Packet builder takes the offered address |
| cpkt_line_o | output | ADDR_W-log2(LINE_WORDS) (14) | Modified line address |
| commit_done_o | output | 1 | One-cycle pulse when the commit has finished |

## Verification
A wrong read mark shows at the port one cycle after the next snoop of that line. A mark that was lost gives a missing `violation_o`. A mark that survived an abort or commit gives a spurious `violation_o`. A mishandled renamed mark shows up the same way. A wrong modified mark shows up in two places: on the commit channel as a missing or extra line address, and after an abort as a load to a line that should have been dropped but still hits, or to a kept line that now misses. That second symptom appears in the load response one cycle after the next access to the line.

// File: rtl/svc_pkg.sv
package svc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DRAIN  = 2'd2
  } txn_state_e;
endpackage

// File: rtl/svc_lowest_set.sv
// Finds the lowest set bit of a vector using a carry-style chain.
module svc_lowest_set #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  bits_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [N:0]   seen;
  logic [N-1:0] first;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign seen[g+1] = seen[g] | bits_i[g];
    assign first[g]  = bits_i[g] & ~seen[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (first[i]) idx_o = idx_o | IW'(i);
    end
  end

  assign any_o = seen[N];
endmodule

// File: rtl/svc_snoop_match.sv
// Compares a snooped line address against the read-marked lines, and
// against a transactional load arriving in the same cycle.
module svc_snoop_match #(
  parameter int LINES = 8,
  parameter int IDX_W = 3,
  parameter int TAG_W = 11,
  localparam int LINE_W = TAG_W + IDX_W
) (
  input  logic [LINES-1:0]            vld_i,
  input  logic [LINES-1:0]            rd_i,
  input  logic [LINES-1:0][TAG_W-1:0] tags_i,
  input  logic                        snoop_valid_i,
  input  logic [LINE_W-1:0]           snoop_line_i,
  input  logic                        local_rd_i,
  input  logic [LINE_W-1:0]           local_line_i,
  output logic                        hit_o
);
  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  logic [LINES-1:0] line_hit;

  assign s_idx = snoop_line_i[IDX_W-1:0];
  assign s_tag = snoop_line_i[LINE_W-1:IDX_W];

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign line_hit[g] = vld_i[g] & rd_i[g] & (tags_i[g] == s_tag) &
                         (s_idx == IDX_W'(g));
  end

  assign hit_o = snoop_valid_i &
                 ((|line_hit) | (local_rd_i & (local_line_i == snoop_line_i)));
endmodule

// File: rtl/svc_commit_drain.sv
// Holds a snapshot of the modified lines and offers them one per transfer.
module svc_commit_drain #(
  parameter int LINES = 8,
  parameter int IDX_W = 3,
  parameter int TAG_W = 11,
  localparam int LINE_W = TAG_W + IDX_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic [LINES-1:0]            mod_i,
  input  logic [LINES-1:0][TAG_W-1:0] tags_i,
  output logic                        cpkt_valid_o,
  input  logic                        cpkt_ready_i,
  output logic [LINE_W-1:0]           cpkt_line_o,
  output logic                        empty_o
);
  logic [LINES-1:0] pend_q;
  logic [IDX_W-1:0] sel;
  logic             any;

  svc_lowest_set #(.N(LINES), .IW(IDX_W)) i_pick (
    .bits_i(pend_q),
    .idx_o (sel),
    .any_o (any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (load_i) begin
      pend_q <= mod_i;
    end else if (any && cpkt_ready_i) begin
      pend_q[sel] <= 1'b0;
    end
  end

  assign cpkt_valid_o = any;
  assign cpkt_line_o  = {tags_i[sel], sel};
  assign empty_o      = ~any;
endmodule

// File: rtl/spec_viol_cache.sv
module spec_viol_cache
  import svc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 4,
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int LINE_W = ADDR_W - WSEL_W,
  localparam int TAG_W  = LINE_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_begin_i,
  input  logic              txn_commit_i,
  input  logic              txn_abort_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              snoop_valid_i,
  input  logic [LINE_W-1:0] snoop_line_i,
  output logic              violation_o,
  output logic              txn_active_o,
  output logic              cpkt_valid_o,
  input  logic              cpkt_ready_i,
  output logic [LINE_W-1:0] cpkt_line_o,
  output logic              commit_done_o
);
  txn_state_e state_q;

  // Per-line and per-word tracking state
  logic [LINES-1:0]                 vld_q, rd_q, mod_q;
  logic [LINES-1:0][TAG_W-1:0]      tag_q;
  logic [LINES-1:0][LINE_WORDS-1:0] ren_q, wv_q;
  logic [DATA_W-1:0]                data_q [LINES][LINE_WORDS];

  logic              viol_q, done_q;
  logic              rsp_valid_q, rsp_hit_q;
  logic [DATA_W-1:0] rsp_data_q;

  // Access decode
  logic [IDX_W-1:0]      a_idx;
  logic [WSEL_W-1:0]     a_word;
  logic [TAG_W-1:0]      a_tag;
  logic [LINE_W-1:0]     a_line;
  logic                  spec, acc, tag_hit, victim_busy, cap_fail, do_acc;
  logic                  is_store, is_load, load_rd_set;
  logic [LINE_WORDS-1:0] wv_line, ren_line;
  logic                  abort_act, drain_load, drain_finish, drain_empty;
  logic                  snp_hit;

  assign a_word = req_addr_i[WSEL_W-1:0];
  assign a_idx  = req_addr_i[WSEL_W +: IDX_W];
  assign a_tag  = req_addr_i[ADDR_W-1 -: TAG_W];
  assign a_line = req_addr_i[ADDR_W-1:WSEL_W];

  assign spec        = (state_q == ST_ACTIVE);
  assign req_ready_o = (state_q != ST_DRAIN) & ~txn_begin_i & ~txn_commit_i & ~txn_abort_i;
  assign acc         = req_valid_i & req_ready_o;
  assign is_store    = req_write_i;
  assign is_load     = ~req_write_i;

  assign tag_hit     = vld_q[a_idx] & (tag_q[a_idx] == a_tag);
  assign victim_busy = ~tag_hit & vld_q[a_idx] & (rd_q[a_idx] | mod_q[a_idx]);
  assign cap_fail    = acc & victim_busy;
  assign do_acc      = acc & ~victim_busy;
  assign load_rd_set = do_acc & is_load & spec & ~(tag_hit & ren_q[a_idx][a_word]);

  always_comb begin
    wv_line  = tag_hit ? wv_q[a_idx]  : '0;
    ren_line = tag_hit ? ren_q[a_idx] : '0;
    if (is_store) begin
      wv_line[a_word] = 1'b1;
      if (spec) ren_line[a_word] = 1'b1;
    end
  end

  assign abort_act    = txn_abort_i & (state_q != ST_DRAIN);
  assign drain_load   = spec & txn_commit_i & ~txn_abort_i & ~viol_q;
  assign drain_finish = (state_q == ST_DRAIN) & drain_empty;

  svc_snoop_match #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_snoop (
    .vld_i        (vld_q),
    .rd_i         (rd_q),
    .tags_i       (tag_q),
    .snoop_valid_i(snoop_valid_i),
    .snoop_line_i (snoop_line_i),
    .local_rd_i   (load_rd_set),
    .local_line_i (a_line),
    .hit_o        (snp_hit)
  );

  svc_commit_drain #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_drain (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (drain_load),
    .mod_i       (mod_q),
    .tags_i      (tag_q),
    .cpkt_valid_o(cpkt_valid_o),
    .cpkt_ready_i(cpkt_ready_i),
    .cpkt_line_o (cpkt_line_o),
    .empty_o     (drain_empty)
  );

  // Transaction state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (txn_begin_i && !txn_abort_i) state_q <= ST_ACTIVE;
        ST_ACTIVE: begin
          if (txn_abort_i)     state_q <= ST_IDLE;
          else if (drain_load) state_q <= ST_DRAIN;
        end
        ST_DRAIN:  if (drain_empty) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // Violation flag and commit completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= drain_finish;
      if (abort_act)                       viol_q <= 1'b0;
      else if (spec && (snp_hit || cap_fail)) viol_q <= 1'b1;
    end
  end

  // Line valid, tag and tracking marks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      tag_q <= '0;
      rd_q  <= '0;
      mod_q <= '0;
      ren_q <= '0;
      wv_q  <= '0;
    end else if (abort_act) begin
      vld_q <= vld_q & ~mod_q;
      rd_q  <= '0;
      mod_q <= '0;
      ren_q <= '0;
    end else if (drain_finish) begin
      rd_q  <= '0;
      mod_q <= '0;
      ren_q <= '0;
    end else if (do_acc) begin
      vld_q[a_idx] <= 1'b1;
      tag_q[a_idx] <= a_tag;
      wv_q[a_idx]  <= wv_line;
      ren_q[a_idx] <= ren_line;
      if (is_store && spec) mod_q[a_idx] <= 1'b1;
      if (load_rd_set)      rd_q[a_idx]  <= 1'b1;
    end
  end

  // Word storage, written only by performed stores
  always_ff @(posedge clk) begin
    if (do_acc && is_store) data_q[a_idx][a_word] <= req_wdata_i;
  end

  // Load response, one cycle after acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= acc & is_load;
      rsp_hit_q   <= acc & is_load & tag_hit & wv_q[a_idx][a_word];
      if (acc && is_load) rsp_data_q <= data_q[a_idx][a_word];
    end
  end

  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_hit_o     = rsp_hit_q;
  assign rsp_rdata_o   = rsp_data_q;
  assign violation_o   = viol_q;
  assign txn_active_o  = (state_q != ST_IDLE);
  assign commit_done_o = done_q;
endmodule

// File: rtl/svc_checker.sv
module svc_checker
  import svc_pkg::*;
#(
  parameter int LINE_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input txn_state_e        state_i,
  input logic              spec_i,
  input logic              snp_hit_i,
  input logic              txn_begin_i,
  input logic              txn_commit_i,
  input logic              txn_abort_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_write_i,
  input logic              rsp_valid_o,
  input logic              violation_o,
  input logic              txn_active_o,
  input logic              cpkt_valid_o,
  input logic              cpkt_ready_i,
  input logic [LINE_W-1:0] cpkt_line_o,
  input logic              commit_done_o
);
  AST_SNOOP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    spec_i && snp_hit_i && !txn_abort_i |=> violation_o);  // R3

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    violation_o && !txn_abort_i |=> violation_o);  // R6

  AST_VIOL_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    violation_o && txn_commit_i && !txn_abort_i |=> !cpkt_valid_o && txn_active_o);  // R6

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    txn_abort_i && state_i != ST_DRAIN |=> !violation_o && !txn_active_o);  // R7

  AST_CPKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cpkt_valid_o && !cpkt_ready_i |=> cpkt_valid_o && $stable(cpkt_line_o));  // R8

  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done_o |-> !txn_active_o && !cpkt_valid_o);  // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state_i == ST_IDLE |-> !violation_o);  // R10

  AST_RSP_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && req_ready_o && !req_write_i |=> rsp_valid_o);  // R11

  AST_RSP_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(req_valid_i && req_ready_o && !req_write_i));  // R11

  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_begin_i || txn_commit_i || txn_abort_i || cpkt_valid_o) |-> !req_ready_o);  // R12
endmodule

bind spec_viol_cache svc_checker #(.LINE_W(LINE_W)) i_svc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .state_i      (state_q),
  .spec_i       (spec),
  .snp_hit_i    (snp_hit),
  .txn_begin_i  (txn_begin_i),
  .txn_commit_i (txn_commit_i),
  .txn_abort_i  (txn_abort_i),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_write_i  (req_write_i),
  .rsp_valid_o  (rsp_valid_o),
  .violation_o  (violation_o),
  .txn_active_o (txn_active_o),
  .cpkt_valid_o (cpkt_valid_o),
  .cpkt_ready_i (cpkt_ready_i),
  .cpkt_line_o  (cpkt_line_o),
  .commit_done_o(commit_done_o)
);

// File: tb/test_spec_viol_cache.sv
`timescale 1ns/100ps
module test_spec_viol_cache;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LINE_W = 14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              txn_begin_i = 0, txn_commit_i = 0, txn_abort_i = 0;
  logic              req_valid_i = 0, req_write_i = 0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_wdata_i = '0;
  logic              req_ready_o, rsp_valid_o, rsp_hit_o;
  logic [DATA_W-1:0] rsp_rdata_o;
  logic              snoop_valid_i = 0;
  logic [LINE_W-1:0] snoop_line_i = '0;
  logic              violation_o, txn_active_o, cpkt_valid_o, commit_done_o;
  logic              cpkt_ready_i = 0;
  logic [LINE_W-1:0] cpkt_line_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spec_viol_cache i_spec_viol_cache (
    .clk(clk), .rst_n(rst_n),
    .txn_begin_i(txn_begin_i), .txn_commit_i(txn_commit_i), .txn_abort_i(txn_abort_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_rdata_o(rsp_rdata_o),
    .snoop_valid_i(snoop_valid_i), .snoop_line_i(snoop_line_i),
    .violation_o(violation_o), .txn_active_o(txn_active_o),
    .cpkt_valid_o(cpkt_valid_o), .cpkt_ready_i(cpkt_ready_i), .cpkt_line_o(cpkt_line_o),
    .commit_done_o(commit_done_o)
  );

  function automatic logic [ADDR_W-1:0] mk(int tag, int idx, int w);
    return {tag[10:0], idx[2:0], w[1:0]};
  endfunction

  function automatic logic [LINE_W-1:0] ln(int tag, int idx);
    return {tag[10:0], idx[2:0]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(int kind);  // 0 begin, 1 commit, 2 abort
    @(negedge clk);
    txn_begin_i  = (kind == 0);
    txn_commit_i = (kind == 1);
    txn_abort_i  = (kind == 2);
    @(posedge clk); #1;
    txn_begin_i = 0; txn_commit_i = 0; txn_abort_i = 0;
  endtask

  task automatic do_load(logic [ADDR_W-1:0] a, output logic hit, output logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1; req_write_i = 0; req_addr_i = a;
    @(posedge clk); #1;
    req_valid_i = 0;
    chk(rsp_valid_o == 1'b1, "R11 rsp_valid", rsp_valid_o, 1);
    hit = rsp_hit_o; d = rsp_rdata_o;
  endtask

  task automatic do_store(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1; req_write_i = 1; req_addr_i = a; req_wdata_i = d;
    @(posedge clk); #1;
    req_valid_i = 0; req_write_i = 0;
  endtask

  task automatic do_snoop(logic [LINE_W-1:0] l);
    @(negedge clk);
    snoop_valid_i = 1; snoop_line_i = l;
    @(posedge clk); #1;
    snoop_valid_i = 0;
  endtask

  task automatic t_reset();
    logic h; logic [31:0] d;
    chk(violation_o == 0 && txn_active_o == 0, "R1 flags", {violation_o, txn_active_o}, 0);
    chk(cpkt_valid_o == 0 && commit_done_o == 0, "R1 commit pins", {cpkt_valid_o, commit_done_o}, 0);
    chk(req_ready_o == 1, "R1 ready", req_ready_o, 1);
    do_load(mk(1, 1, 0), h, d);
    chk(h == 0, "R1 miss after reset", h, 0);
  endtask

  task automatic t_outside();
    logic h; logic [31:0] d;
    do_load(mk(2, 0, 1), h, d);
    do_snoop(ln(2, 0));
    chk(violation_o == 0, "R10 snoop outside txn", violation_o, 0);
  endtask

  task automatic t_read_violation();
    logic h; logic [31:0] d;
    strobe(0);
    chk(txn_active_o == 1, "R2 begin opens", txn_active_o, 1);
    do_load(mk(1, 1, 0), h, d);
    do_snoop(ln(1, 0));
    chk(violation_o == 0, "R3 other line no violation", violation_o, 0);
    do_snoop(ln(1, 1));
    chk(violation_o == 1, "R3 read line snooped", violation_o, 1);
    repeat (3) @(posedge clk);
    #1 chk(violation_o == 1, "R6 sticky", violation_o, 1);
    strobe(1);
    repeat (2) begin
      @(negedge clk);
      chk(cpkt_valid_o == 0 && commit_done_o == 0, "R6 commit ignored",
          {cpkt_valid_o, commit_done_o}, 0);
    end
    chk(txn_active_o == 1 && violation_o == 1 && req_ready_o == 1, "R6 still open",
        {txn_active_o, violation_o, req_ready_o}, 3'b111);
    strobe(2);
    chk(violation_o == 0 && txn_active_o == 0, "R2 R7 abort closes", {violation_o, txn_active_o}, 0);
  endtask

  task automatic t_renamed();
    logic h; logic [31:0] d;
    strobe(0);
    do_store(mk(1, 1, 2), 32'hCAFE0002);
    do_load(mk(1, 1, 2), h, d);
    chk(h == 1 && d == 32'hCAFE0002, "R11 load own store", d, 32'hCAFE0002);
    do_snoop(ln(1, 1));
    chk(violation_o == 0, "R4 renamed word read no violation", violation_o, 0);
    do_load(mk(1, 1, 1), h, d);
    chk(h == 0, "R11 unwritten word misses", h, 0);
    do_snoop(ln(1, 1));
    chk(violation_o == 1, "R4 other word read violates", violation_o, 1);
    strobe(2);
    do_load(mk(1, 1, 2), h, d);
    chk(h == 0, "R7 modified line dropped", h, 0);
  endtask

  task automatic t_same_cycle();
    strobe(0);
    @(negedge clk);
    req_valid_i = 1; req_write_i = 0; req_addr_i = mk(2, 0, 3);
    snoop_valid_i = 1; snoop_line_i = ln(3, 0);
    @(posedge clk); #1;
    req_valid_i = 0; snoop_valid_i = 0;
    chk(violation_o == 0, "R5 different tag same cycle", violation_o, 0);
    @(negedge clk);
    req_valid_i = 1; req_write_i = 0; req_addr_i = mk(4, 6, 0);
    snoop_valid_i = 1; snoop_line_i = ln(4, 6);
    @(posedge clk); #1;
    req_valid_i = 0; snoop_valid_i = 0;
    chk(violation_o == 1, "R5 same-cycle load and snoop", violation_o, 1);
    strobe(2);
  endtask

  task automatic t_abort_keeps();
    logic h; logic [31:0] d;
    do_store(mk(5, 3, 0), 32'hAAAA5555);
    strobe(0);
    do_load(mk(5, 3, 0), h, d);
    chk(h == 1 && d == 32'hAAAA5555, "R11 hit data", d, 32'hAAAA5555);
    do_store(mk(2, 7, 1), 32'h11112222);
    strobe(2);
    do_load(mk(5, 3, 0), h, d);
    chk(h == 1 && d == 32'hAAAA5555, "R7 read line kept", d, 32'hAAAA5555);
    do_load(mk(2, 7, 1), h, d);
    chk(h == 0, "R7 stored line invalidated", h, 0);
  endtask

  task automatic t_commit();
    logic h; logic [31:0] d;
    logic [LINE_W-1:0] exp_l [3];
    int n = 0;
    int cyc = 0;
    bit seen_done = 0;
    exp_l[0] = ln(9, 2); exp_l[1] = ln(3, 5); exp_l[2] = ln(4, 6);
    strobe(0);
    do_store(mk(3, 5, 1), 32'h00000501);
    do_store(mk(9, 2, 0), 32'h00000200);
    do_store(mk(4, 6, 3), 32'h00000603);
    do_load(mk(5, 3, 0), h, d);
    strobe(1);
    while (!seen_done && cyc < 30) begin
      @(negedge clk);
      cpkt_ready_i = (cyc >= 2);
      if (cyc == 1) chk(cpkt_valid_o == 1 && cpkt_line_o == exp_l[0], "R8 held under back-pressure",
                        cpkt_line_o, exp_l[0]);
      if (cpkt_valid_o) chk(req_ready_o == 0, "R12 blocked while draining", req_ready_o, 0);
      if (commit_done_o) begin
        seen_done = 1;
        chk(n == 3, "R8 entry count at done", n, 3);
      end
      if (cpkt_valid_o && cpkt_ready_i) begin
        if (n < 3) chk(cpkt_line_o == exp_l[n], "R8 line order", cpkt_line_o, exp_l[n]);
        n++;
      end
      cyc++;
    end
    cpkt_ready_i = 0;
    chk(seen_done == 1, "R8 done pulse", seen_done, 1);
    chk(n == 3, "R8 three entries", n, 3);
    @(negedge clk);
    chk(commit_done_o == 0 && txn_active_o == 0, "R8 single pulse and closed",
        {commit_done_o, txn_active_o}, 0);
    do_load(mk(3, 5, 1), h, d);
    chk(h == 1 && d == 32'h00000501, "R8 committed data kept", d, 32'h00000501);
    strobe(0);
    do_snoop(ln(5, 3));
    chk(violation_o == 0, "R8 read mark cleared", violation_o, 0);
    strobe(2);
  endtask

  task automatic t_capacity();
    logic h; logic [31:0] d;
    strobe(0);
    do_load(mk(7, 4, 0), h, d);
    do_store(mk(8, 4, 1), 32'hDEADBEEF);
    chk(violation_o == 1, "R9 capacity violation", violation_o, 1);
    strobe(2);
    do_load(mk(8, 4, 1), h, d);
    chk(h == 0, "R9 store not performed", h, 0);
    strobe(0);
    do_store(mk(6, 0, 0), 32'h1);
    do_load(mk(2, 0, 0), h, d);
    chk(violation_o == 1 && h == 0, "R9 load refused", {violation_o, h}, 2'b10);
    strobe(2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_outside();
    t_read_violation();
    t_renamed();
    t_same_cycle();
    t_abort_keeps();
    t_commit();
    t_capacity();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule